// File: doc/BRIEF.md
# Four-Clock External Bus Cycle Controller

This block sits between a single-clock processor core and slow external asynchronous memory. Each core access becomes a bus cycle built from four system clocks. A free-running phase counter produces a two-phase strobe pair with no second clock: `phi2` is high for two clocks and low for two, and `phi1` is its complement. At a 73.728 MHz system clock the strobe period gives an access rate of 18.432 MHz and a `phi2` high window of about 27 ns. That window fits ordinary asynchronous SRAM with no wait states.

Every pin toward memory comes from a flip-flop: address, read/write flag, write data, data drive enable, write strobe and output enable. The read data is captured in an input register. Because of this, skew between address bits is limited to register-to-pin skew. Slower devices are handled with a per-access wait count. Each wait state adds one complete four-clock strobe period with the address and strobes held, and the `phi1`/`phi2` waveform never changes. A 70 ns Flash device, for example, uses one wait state.

The core raises a request with address, write data, direction and wait count, and holds all of them until a one-clock ready pulse. Read data is valid during that ready clock.

Top module: `bus_cycle_ctl`

## Requirements
- R1: After reset the strobes repeat with a period of four clocks. `phi2` is low for two clocks and then high for two clocks. `phi1` is always the inverse of `phi2`. Phase 0 is the first of the two low clocks.
- R2: `mem_addr` and `mem_rnw` change only on the clock edge that starts phase 0 (`phi2` falls at that edge). They hold their values between accesses.
- R3: For a write access (`core_rnw`=0), `mem_we_n` is low and `mem_dout_en` is high for exactly the clocks in which `phi2` is high, in every strobe period of the access. `mem_dout` carries the request's write data during the access.
- R4: For a read access (`core_rnw`=1), `mem_oe_n` is low for exactly the clocks in which `phi2` is high, in every strobe period of the access. `mem_din` is captured on the edge at which `phi2` falls in the last period, and is presented on `core_rdata`.
- R5: A wait count N (0 to 3) on `core_wait`, sampled when the request is accepted, makes the access last N+1 strobe periods. Over the whole access the strobe is active for 2*(N+1) clocks.
- R6: `core_rdy` is high for exactly one clock: phase 0 directly after the last period of an access. For reads, `core_rdata` is valid in that clock.
- R7: A request is accepted only on the edge that starts phase 0, and only when no access is in progress. A request raised mid-period starts at the next phase 0. A request held through its own ready pulse is not taken a second time. The next access begins in the following period.
- R8: While `rst_n` is low, the following clock edge sets phase 0 with `phi2`=0, `phi1`=1, `mem_we_n`=1, `mem_oe_n`=1, `mem_dout_en`=0, `core_rdy`=0, `mem_rnw`=1 and `mem_addr`=0.
- R9: With no request, the strobes keep running while `mem_we_n`, `mem_oe_n` and `mem_dout_en` stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core access request, held until `core_rdy` |
| core_rnw | input | 1 | 1 = read, 0 = write |
| core_addr | input | ADDR_W | Access address |
| core_wdata | input | DATA_W | Write data |
| core_wait | input | WAIT_W | Wait states for this access (0..3) |
| core_rdy | output | 1 | One-clock completion pulse |
| core_rdata | output | DATA_W | Captured read data |
| phi1 | output | 1 | Registered strobe, inverse of `phi2` |
| phi2 | output | 1 | Registered access strobe |
| mem_addr | output | ADDR_W | Registered memory address |
| mem_rnw | output | 1 | Registered direction flag |
| mem_dout | output | DATA_W | Registered write data |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_din | input | DATA_W | Read data from memory |

## Verification
The completion of one access and the acceptance of the next both fall on the edge that starts phase 0. On that edge the read data is captured and the ready pulse is set up, while a pending request is sampled. The bench provokes this by keeping `core_req` high through the ready clock and presenting a new access in that same clock. The behavioural model then expects no second copy of the first access: one idle period follows, then the new access. The strobe counts and the read data are compared clock by clock.

// File: rtl/bcc_pkg.sv
// Package: shared phase type and phase constants for the bus cycle controller.
// Assumes a four-clock strobe period, encoded on two bits.
package bcc_pkg;
    localparam int PH_W = 2;
    typedef logic [PH_W-1:0] phase_t;
    localparam phase_t PH_START = 2'd0;   // first phi2-low clock
    localparam phase_t PH_LAST  = 2'd3;   // last phi2-high clock
endpackage

// File: rtl/bcc_phase_gen.sv
// Phase generator: free-running 0..3 counter that derives registered phi1/phi2.
// phi2 is high in phases 2 and 3. Assumes a synchronous active-low reset.
module bcc_phase_gen
    import bcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t ph,
    output logic   ph_end,     // current clock is the last of the period
    output logic   nxt_hi,     // phi2 level in the next clock
    output logic   phi1,
    output logic   phi2
);
    phase_t nxt_ph;

    // Next phase and derived decodes
    always_comb begin
        nxt_ph = ph + 1'b1;
        nxt_hi = nxt_ph[PH_W-1];
        ph_end = (ph == PH_LAST);
    end

    // Phase counter and strobe flops (R1, R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_START;
            phi2 <= 1'b0;
            phi1 <= 1'b1;
        end else begin
            ph   <= nxt_ph;
            phi2 <= nxt_hi;
            phi1 <= ~nxt_hi;
        end
    end
endmodule

// File: rtl/bcc_access_ctl.sv
// Access controller: accepts a request at the period boundary, counts wait
// periods and raises a one-clock ready. Assumes the core holds its request.
module bcc_access_ctl #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_end,
    input  logic              req,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              load,
    output logic              done,
    output logic              busy_nxt,
    output logic              rdy
);
    logic              busy;
    logic [WAIT_W-1:0] wleft;

    // Accept / finish decisions, all on the period boundary (R5, R7)
    always_comb begin
        load     = ph_end && !busy && req;
        done     = ph_end && busy && (wleft == '0);
        busy_nxt = load || (busy && !done);
    end

    // Busy flag, remaining wait periods and ready pulse (R6)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            wleft <= '0;
            rdy   <= 1'b0;
        end else begin
            busy <= busy_nxt;
            rdy  <= done;
            if (load)
                wleft <= wait_in;
            else if (ph_end && busy && !done)
                wleft <= wleft - 1'b1;
        end
    end
endmodule

// File: rtl/bcc_pin_regs.sv
// Pin register stage: holds address, direction and write data, registers the
// strobes from next-state values and captures read data. All pins are flops.
module bcc_pin_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              done,
    input  logic              busy_nxt,
    input  logic              nxt_hi,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rnw_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rnw,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] rdata
);
    logic rnw_nxt;
    logic drive;

    // Direction and strobe window for the coming clock
    always_comb begin
        rnw_nxt = load ? rnw_in : mem_rnw;
        drive   = busy_nxt && nxt_hi;
    end

    // Address/data holding registers, loaded only at acceptance (R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_rnw  <= 1'b1;
            mem_dout <= '0;
        end else if (load) begin
            mem_addr <= addr_in;
            mem_rnw  <= rnw_in;
            mem_dout <= wdata_in;
        end
    end

    // Strobe flops, active only while phi2 is high (R3, R4, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we_n    <= 1'b1;
            mem_oe_n    <= 1'b1;
            mem_dout_en <= 1'b0;
        end else begin
            mem_we_n    <= !(drive && !rnw_nxt);
            mem_dout_en <= drive && !rnw_nxt;
            mem_oe_n    <= !(drive && rnw_nxt);
        end
    end

    // Read data input register, sampled as phi2 falls in the last period (R4)
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (done && mem_rnw)
            rdata <= mem_din;
    end
endmodule

// File: rtl/bus_cycle_ctl.sv
// Top: four-clock external bus cycle controller. Turns held core requests into
// strobed memory cycles with whole-period wait states. Assumes one clock domain.
module bus_cycle_ctl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_rnw,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [WAIT_W-1:0] core_wait,
    output logic              core_rdy,
    output logic [DATA_W-1:0] core_rdata,
    output logic              phi1,
    output logic              phi2,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rnw,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_din
);
    import bcc_pkg::*;

    phase_t ph;
    logic   ph_end, nxt_hi, load, done, busy_nxt;

    bcc_phase_gen u_phase (
        .clk(clk), .rst_n(rst_n), .ph(ph), .ph_end(ph_end),
        .nxt_hi(nxt_hi), .phi1(phi1), .phi2(phi2)
    );

    bcc_access_ctl #(.WAIT_W(WAIT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ph_end(ph_end), .req(core_req),
        .wait_in(core_wait), .load(load), .done(done),
        .busy_nxt(busy_nxt), .rdy(core_rdy)
    );

    bcc_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .load(load), .done(done),
        .busy_nxt(busy_nxt), .nxt_hi(nxt_hi), .addr_in(core_addr),
        .rnw_in(core_rnw), .wdata_in(core_wdata), .mem_din(mem_din),
        .mem_addr(mem_addr), .mem_rnw(mem_rnw), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .rdata(core_rdata)
    );
endmodule

// File: rtl/bcc_checks.sv
// Checker: temporal properties on the controller's ports, bound to the top.
module bcc_checks #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi1,
    input logic              phi2,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              core_rdy
);
    a_r1_high_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi2) |=> (phi2 ##1 !phi2));
    a_r1_low_two: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi2) |=> (!phi2 ##1 phi2));
    a_r1_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        phi1 != phi2);
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (!phi2 && $past(phi2)));
    a_r3_strobe_in_phi2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> phi2);
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    a_r6_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_rdy |=> !core_rdy);
    a_r6_rdy_phase0: assert property (@(posedge clk) disable iff (!rst_n)
        core_rdy |-> (!phi2 && $past(phi2)));
    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!phi2 && phi1 && mem_we_n && mem_oe_n && !core_rdy));
endmodule

bind bus_cycle_ctl bcc_checks #(.ADDR_W(ADDR_W)) u_bcc_checks (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .mem_addr(mem_addr), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .core_rdy(core_rdy)
);

// File: tb/bus_cycle_ctl_bench.sv
`timescale 1ns/1ps
module bus_cycle_ctl_bench;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int WW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          core_req = 1'b0, core_rnw = 1'b1;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [WW-1:0] core_wait = '0;
    logic          core_rdy, phi1, phi2, mem_rnw, mem_dout_en, mem_we_n, mem_oe_n;
    logic [DW-1:0] core_rdata, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;

    bus_cycle_ctl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u_bus_cycle_ctl (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_rnw(core_rnw),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_wait(core_wait),
        .core_rdy(core_rdy), .core_rdata(core_rdata), .phi1(phi1), .phi2(phi2),
        .mem_addr(mem_addr), .mem_rnw(mem_rnw), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_din(mem_din)
    );

    // Simple asynchronous memory: drives data while enabled, stores on write strobe
    logic [DW-1:0] mem_arr [256];
    assign mem_din = mem_oe_n ? 8'hA5 : mem_arr[mem_addr[7:0]];
    always @(posedge clk) if (!mem_we_n && mem_dout_en) mem_arr[mem_addr[7:0]] <= mem_dout;

    int vectors = 0, miscompares = 0;
    bit cmp_on = 0, finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int            m_ph = 0, m_wl = 0;
    bit            m_busy = 0, m_rdy = 0, m_wr = 0, m_rnw = 1;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0, m_rdata = '0;
    always @(posedge clk) begin
        bit boundary, finish, take;
        if (!rst_n) begin
            m_ph = 0; m_busy = 0; m_rdy = 0; m_wl = 0; m_addr = '0; m_rnw = 1;
            m_rdata = '0;
        end else begin
            boundary = (m_ph == 3);
            finish = boundary && m_busy && (m_wl == 0);
            take = boundary && !m_busy && core_req;
            m_rdy = finish;
            if (finish) begin
                m_busy = 0;
                if (!m_wr) m_rdata = mem_arr[m_addr[7:0]];
            end else if (boundary && m_busy) m_wl = m_wl - 1;
            if (take) begin
                m_busy = 1; m_wl = core_wait; m_addr = core_addr;
                m_wr = !core_rnw; m_rnw = core_rnw; m_wd = core_wdata;
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    // Clock-by-clock comparison away from the active edge
    always @(negedge clk) if (cmp_on) begin
        check("R1 phi2", phi2, m_ph >= 2);
        check("R1 phi1", phi1, m_ph < 2);
        check("R3 we_n", mem_we_n, !(m_busy && m_wr && m_ph >= 2));
        check("R3 dout_en", mem_dout_en, m_busy && m_wr && m_ph >= 2);
        check("R4 oe_n", mem_oe_n, !(m_busy && !m_wr && m_ph >= 2));
        check("R6 rdy", core_rdy, m_rdy);
        check("R2 addr", mem_addr, m_addr);
        check("R2 rnw", mem_rnw, m_rnw);
        if (m_busy && m_wr) check("R3 dout", mem_dout, m_wd);
        if (m_rdy && !m_wr) check("R4 rdata", core_rdata, m_rdata);
    end

    // One access; caller is at a falling edge. keep leaves the request high.
    task automatic access(input logic [AW-1:0] a, input bit rnw, input logic [DW-1:0] d,
                          input int w, input bit keep, output logic [DW-1:0] rd,
                          output int oe_cnt, output int we_cnt);
        core_req = 1; core_addr = a; core_rnw = rnw; core_wdata = d; core_wait = w[WW-1:0];
        oe_cnt = 0; we_cnt = 0;
        do begin
            @(negedge clk);
            if (!mem_oe_n) oe_cnt++;
            if (!mem_we_n) we_cnt++;
        end while (!core_rdy);
        rd = core_rdata;
        if (!keep) core_req = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        logic [DW-1:0] rd;
        int oe_c, we_c, idle_strobes;
        for (int i = 0; i < 256; i++) mem_arr[i] = 8'(i * 7 + 3);
        @(posedge clk); #1 cmp_on = 1;
        repeat (3) @(negedge clk);
        check("R8 phi2 in reset", phi2, 0);
        check("R8 phi1 in reset", phi1, 1);
        check("R8 strobes in reset", {mem_we_n, mem_oe_n, mem_dout_en}, 3'b110);
        check("R8 rdy/rnw/addr in reset", {core_rdy, mem_rnw, mem_addr}, {1'b0, 1'b1, 16'h0});
        rst_n = 1;
        idle_strobes = 0;
        repeat (12) begin
            @(negedge clk);
            if (!mem_we_n || !mem_oe_n || mem_dout_en) idle_strobes++;
        end
        check("R9 idle strobes", idle_strobes, 0);

        access(16'h1040, 0, 8'h3C, 0, 0, rd, oe_c, we_c);
        check("R3 write strobe clocks, no wait", we_c, 2);
        check("R3 no oe on write", oe_c, 0);
        @(negedge clk);
        access(16'h1040, 1, 8'h00, 0, 0, rd, oe_c, we_c);
        check("R4 read back", rd, 8'h3C);
        check("R5 oe clocks, no wait", oe_c, 2);

        @(negedge clk);
        access(16'h2081, 0, 8'hC9, 1, 0, rd, oe_c, we_c);
        check("R5 write strobe clocks, one wait", we_c, 4);
        @(negedge clk);
        access(16'h2081, 1, 8'h00, 3, 0, rd, oe_c, we_c);
        check("R5 oe clocks, three waits", oe_c, 8);
        check("R4 read back after waits", rd, 8'hC9);
        @(negedge clk);
        access(16'h30F0, 1, 8'h00, 1, 0, rd, oe_c, we_c);
        check("R4 preloaded read, one wait", rd, 8'((8'hF0) * 7 + 3));

        // R7: raise the request while phi2 is high, mid-period
        while (!phi2) @(negedge clk);
        access(16'h0011, 1, 8'h00, 2, 0, rd, oe_c, we_c);
        check("R7 mid-period request oe clocks", oe_c, 6);
        check("R7 mid-period request data", rd, 8'(8'h11 * 7 + 3));

        // R7/R6: request kept high through ready, next access presented at once
        @(negedge clk);
        access(16'h0050, 0, 8'h77, 0, 1, rd, oe_c, we_c);
        check("R7 held write strobe clocks", we_c, 2);
        access(16'h0050, 1, 8'h00, 0, 0, rd, oe_c, we_c);
        check("R7 back-to-back read", rd, 8'h77);
        check("R6 back-to-back oe clocks", oe_c, 2);

        repeat (8) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule